// File: doc/BRIEF.md
# Masked Vector Gather Load Sequencer

The block fills a 256-bit vector register with 32-bit words read from memory, one word per element. A per-element mask selects which elements are loaded. Each element's address is a base plus a sign-extended index, either 32 or 64 bits wide, shifted by a scale of 1, 2, 4 or 8, plus a signed 32-bit displacement. After a start pulse the block latches its operands and normalises the mask. It then walks the active elements from lowest to highest and issues one single-word load at a time over a valid/ready request port. It waits for each response and merges the data into the destination image it returns.

Each element that completes has its mask field cleared. A response that carries a fault stops the walk at that element. Elements below it are finished, and the faulting element and all elements above it keep an active mask. The returned destination and mask can therefore be fed back unchanged to resume the operation. Lanes that belong to no element, given the index width and the vector length, are forced to zero. An illegal operand combination is reported at once and makes no memory access.

Top module: `vgather_seq`

## Requirements
- R1: At start, each 32-bit mask lane that maps to an element becomes all ones when its bit 31 is set and all zeros otherwise. This normalised value is what a fault leaves in the faulting and higher lanes.
- R2: An element's request address is base + sign-extended index × 2^scale_i + sign-extended disp_i, taken modulo 2^64. Odd or misaligned addresses are requested unchanged and never cause a fault by themselves.
- R3: With idx64_i=0, element j uses index bits [32j+31:32j], and there are 4 elements (wide_i=0) or 8 elements (wide_i=1). With idx64_i=1, element j uses bits [64j+63:64j], and there are 2 or 4 elements.
- R4: An element with an active mask lane receives the word returned for its address. An element with an inactive lane keeps its dest_i value.
- R5: When the operation completes without fault or illegal condition, done_o is 1 and the whole mask_o is zero.
- R6: For a legal operation, the mask_o and dest_o lanes whose number is equal to or above the element count are zero. This includes operations that fault on their first element.
- R7: A response with rsp_fault_i=1 ends the operation. done_o and fault_o rise in the same cycle, and fault_elem_o holds that element's number. Every lower element is merged with its mask lane cleared, the faulting and higher active lanes keep all ones, and feeding the outputs back as a new start completes the rest.
- R8: With amode_i=2'b01 (32-bit addressing), request address bits 63:32 are zero, and carries or scaled index bits beyond bit 31 are dropped. With amode_i=2'b1x, all 64 bits are used.
- R9: If any two of idx_reg_i, mask_reg_i and dest_reg_i are equal, or amode_i=2'b00, or sib_i=0, the block raises done_o and illegal_o without any request. mask_o and dest_o then equal mask_i and dest_i.
- R10: Requests are issued in ascending element order with at most one outstanding. req_valid_o and req_addr_o hold steady until req_ready_i is seen.
- R11: A start pulse while busy is ignored. From done_o until the next accepted start, done_o stays 1 and all outputs stay stable. After reset, done_o, fault_o, illegal_o and req_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle or done |
| base_i | input | 64 | Common base address |
| index_i | input | 256 | Index vector (32- or 64-bit signed lanes) |
| idx64_i | input | 1 | 1 selects 64-bit indices |
| scale_i | input | 2 | Scale code, factor 2^scale_i |
| disp_i | input | 32 | Signed displacement |
| amode_i | input | 2 | Address size: 00 16-bit, 01 32-bit, 1x 64-bit |
| wide_i | input | 1 | 1 selects the 256-bit vector length |
| mask_i | input | 256 | Incoming mask vector |
| dest_i | input | 256 | Prior destination vector |
| idx_reg_i | input | 4 | Identifier of the index register |
| mask_reg_i | input | 4 | Identifier of the mask register |
| dest_reg_i | input | 4 | Identifier of the destination register |
| sib_i | input | 1 | Operand encoding carries a scaled-index byte |
| req_valid_o | output | 1 | Load request valid |
| req_addr_o | output | 64 | Load request address |
| req_ready_i | input | 1 | Memory accepts the request |
| rsp_valid_i | input | 1 | Load response valid |
| rsp_data_i | input | 32 | Loaded word |
| rsp_fault_i | input | 1 | Load faulted |
| dest_o | output | 256 | Updated destination vector |
| mask_o | output | 256 | Updated mask vector |
| done_o | output | 1 | Operation finished (level until next start) |
| fault_o | output | 1 | Operation stopped on a faulting load |
| fault_elem_o | output | 3 | Number of the faulting element |
| illegal_o | output | 1 | Illegal operand combination |

## Verification
The assertions check, on every cycle, the rules that hold at every step of a walk. The request must stay steady under backpressure, and no active lane may sit below the element being requested. Lanes above the element count must stay zero, and no request may follow an illegal start. A fault must coincide with done and leave its own lane active, a clean finish must leave an empty mask, and outputs must hold after done. The address arithmetic with negative and 64-bit indices, truncation under 32-bit addressing, and the exact words merged into each lane depend on concrete data, so only the bench scenarios can show them. The same holds for the partial result at a fault and for resuming from it.

// File: rtl/vgather_pkg.sv
package vgather_pkg;

  typedef enum logic [1:0] {
    GS_IDLE,
    GS_RUN,
    GS_WAIT,
    GS_DONE
  } gstate_e;

  // Number of elements gathered for an index width and vector length.
  function automatic int unsigned elem_count(input logic idx64, input logic wide,
                                             input int unsigned lanes);
    int unsigned n;
    n = wide ? lanes : lanes / 2;
    if (idx64) n = n / 2;
    return n;
  endfunction

  // True when the operand set cannot be executed.
  function automatic logic operands_bad(input logic [7:0] rid_a, input logic [7:0] rid_b,
                                        input logic [7:0] rid_c, input logic [1:0] amode,
                                        input logic sib);
    return (rid_a == rid_b) || (rid_a == rid_c) || (rid_b == rid_c) ||
           (amode == 2'b00) || !sib;
  endfunction

endpackage

// File: rtl/vgather_agen.sv
module vgather_agen #(
  parameter int unsigned AW  = 64,
  parameter int unsigned NAW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] sidx,
  input  logic [1:0]    scale,
  input  logic [31:0]   disp,
  input  logic          narrow,
  output logic [AW-1:0] addr
);

  function automatic logic [AW-1:0] form_addr(input logic [AW-1:0] b, input logic [AW-1:0] x,
                                              input logic [1:0] s, input logic [31:0] d,
                                              input logic nr);
    logic [AW-1:0] sum;
    logic [AW-1:0] keep;
    sum  = b + (x << s) + AW'($signed(d));
    keep = {{(AW-NAW){1'b0}}, {NAW{1'b1}}};
    return nr ? (sum & keep) : sum;
  endfunction

  assign addr = form_addr(base, sidx, scale, disp, narrow);

endmodule

// File: rtl/vgather_pick.sv
module vgather_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  act,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (act[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end

endmodule

// File: rtl/vgather_seq.sv
module vgather_seq
  import vgather_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 64,
  parameter int unsigned NAW   = 32,
  parameter int unsigned RID_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [AW-1:0]              base_i,
  input  logic [LANES*DW-1:0]        index_i,
  input  logic                       idx64_i,
  input  logic [1:0]                 scale_i,
  input  logic [31:0]                disp_i,
  input  logic [1:0]                 amode_i,
  input  logic                       wide_i,
  input  logic [LANES*DW-1:0]        mask_i,
  input  logic [LANES*DW-1:0]        dest_i,
  input  logic [RID_W-1:0]           idx_reg_i,
  input  logic [RID_W-1:0]           mask_reg_i,
  input  logic [RID_W-1:0]           dest_reg_i,
  input  logic                       sib_i,
  output logic                       req_valid_o,
  output logic [AW-1:0]              req_addr_o,
  input  logic                       req_ready_i,
  input  logic                       rsp_valid_i,
  input  logic [DW-1:0]              rsp_data_i,
  input  logic                       rsp_fault_i,
  output logic [LANES*DW-1:0]        dest_o,
  output logic [LANES*DW-1:0]        mask_o,
  output logic                       done_o,
  output logic                       fault_o,
  output logic [$clog2(LANES)-1:0]   fault_elem_o,
  output logic                       illegal_o
);

  localparam int unsigned VW    = LANES * DW;
  localparam int unsigned IXW   = 2 * DW;
  localparam int unsigned HALF  = LANES / 2;
  localparam int unsigned EIW   = $clog2(LANES);
  localparam int unsigned CNT_W = EIW + 1;

  gstate_e             st;
  logic [VW-1:0]       mask_q, dest_q, index_q;
  logic [AW-1:0]       base_q;
  logic [31:0]         disp_q;
  logic [1:0]          scale_q;
  logic                idx64_q, narrow_q, bad_q;
  logic [CNT_W-1:0]    n_q;
  logic [EIW-1:0]      cur_q;
  logic                done_q, fault_q, ill_q;
  logic [EIW-1:0]      felem_q;

  // Named events used by the datapath and the assertions.
  logic                start_ok, req_fire, rsp_ok, rsp_bad, finish_ok;
  logic                bad_start;
  logic [CNT_W-1:0]    n_start;
  logic [VW-1:0]       mask_load, dest_load;
  logic [LANES-1:0]    act, below_act, tail_ok;
  logic [AW-1:0]       lane_sidx [LANES];
  logic                found;
  logic [EIW-1:0]      pick_idx;
  logic [AW-1:0]       sel_sidx;

  assign n_start   = CNT_W'(elem_count(idx64_i, wide_i, LANES));
  assign bad_start = operands_bad(8'(idx_reg_i), 8'(mask_reg_i), 8'(dest_reg_i),
                                  amode_i, sib_i);
  assign start_ok  = start_i && ((st == GS_IDLE) || (st == GS_DONE));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic live_in;
    assign live_in = (g < int'(n_start));
    assign mask_load[g*DW +: DW] = live_in ? {DW{mask_i[g*DW + DW - 1]}} : '0;
    assign dest_load[g*DW +: DW] = live_in ? dest_i[g*DW +: DW] : '0;
    assign act[g]       = mask_q[g*DW + DW - 1];
    assign below_act[g] = act[g] && (g < int'(pick_idx));
    assign tail_ok[g]   = (g < int'(n_q)) ||
                          ((mask_q[g*DW +: DW] == '0) && (dest_q[g*DW +: DW] == '0));
    if (g < HALF) begin : g_wide
      assign lane_sidx[g] = idx64_q ? AW'($signed(index_q[g*IXW +: IXW]))
                                    : AW'($signed(index_q[g*DW +: DW]));
    end else begin : g_narrow
      assign lane_sidx[g] = idx64_q ? '0 : AW'($signed(index_q[g*DW +: DW]));
    end
  end

  vgather_pick #(.N(LANES), .IW(EIW)) u_pick (
    .act   (act),
    .found (found),
    .idx   (pick_idx)
  );

  assign sel_sidx = lane_sidx[pick_idx];

  vgather_agen #(.AW(AW), .NAW(NAW)) u_agen (
    .base   (base_q),
    .sidx   (sel_sidx),
    .scale  (scale_q),
    .disp   (disp_q),
    .narrow (narrow_q),
    .addr   (req_addr_o)
  );

  assign req_valid_o = (st == GS_RUN) && !bad_q && found;
  assign req_fire    = req_valid_o && req_ready_i;
  assign finish_ok   = (st == GS_RUN) && (bad_q || !found);
  assign rsp_ok      = (st == GS_WAIT) && rsp_valid_i && !rsp_fault_i;
  assign rsp_bad     = (st == GS_WAIT) && rsp_valid_i && rsp_fault_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= GS_IDLE;
      mask_q   <= '0;
      dest_q   <= '0;
      index_q  <= '0;
      base_q   <= '0;
      disp_q   <= '0;
      scale_q  <= '0;
      idx64_q  <= 1'b0;
      narrow_q <= 1'b0;
      bad_q    <= 1'b0;
      n_q      <= '0;
      cur_q    <= '0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      ill_q    <= 1'b0;
      felem_q  <= '0;
    end else if (start_ok) begin
      st       <= GS_RUN;
      mask_q   <= bad_start ? mask_i : mask_load;
      dest_q   <= bad_start ? dest_i : dest_load;
      index_q  <= index_i;
      base_q   <= base_i;
      disp_q   <= disp_i;
      scale_q  <= scale_i;
      idx64_q  <= idx64_i;
      narrow_q <= (amode_i == 2'b01);
      bad_q    <= bad_start;
      n_q      <= n_start;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      ill_q    <= 1'b0;
      felem_q  <= '0;
    end else begin
      case (st)
        GS_RUN: begin
          if (finish_ok) begin
            st     <= GS_DONE;
            done_q <= 1'b1;
            ill_q  <= bad_q;
          end else if (req_fire) begin
            st    <= GS_WAIT;
            cur_q <= pick_idx;
          end
        end
        GS_WAIT: begin
          if (rsp_ok) begin
            dest_q[int'(cur_q)*DW +: DW] <= rsp_data_i;
            mask_q[int'(cur_q)*DW +: DW] <= '0;
            st <= GS_RUN;
          end else if (rsp_bad) begin
            st      <= GS_DONE;
            done_q  <= 1'b1;
            fault_q <= 1'b1;
            felem_q <= cur_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign dest_o       = dest_q;
  assign mask_o       = mask_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_elem_o = felem_q;
  assign illegal_o    = ill_q;

  // R10: the request is held steady under backpressure
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  // R10: no active lane is left below the element being requested
  p_ascending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (below_act == '0));

  // R7: a fault always arrives together with done and keeps its lane active
  p_fault_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o && mask_o[int'(fault_elem_o)*DW + DW - 1]);

  // R5: a clean finish leaves an empty mask
  p_clean_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fault_o && !illegal_o |-> (mask_o == '0));

  // R6: lanes mapped to no element stay zero during and after a legal operation
  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != GS_IDLE) && !bad_q |-> (&tail_ok));

  // R9: an illegal operation never reaches memory
  p_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !req_valid_o);

  // R11: results hold from done until a new start
  p_hold_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(dest_o) && $stable(mask_o) && $stable(fault_o));

endmodule

// File: tb/vgather_seq_tb.sv
module vgather_seq_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  base_i = '0;
  logic [255:0] index_i = '0;
  logic         idx64_i = 1'b0;
  logic [1:0]   scale_i = '0;
  logic [31:0]  disp_i = '0;
  logic [1:0]   amode_i = 2'b10;
  logic         wide_i = 1'b0;
  logic [255:0] mask_i = '0;
  logic [255:0] dest_i = '0;
  logic [3:0]   idx_reg_i = 4'd1, mask_reg_i = 4'd2, dest_reg_i = 4'd3;
  logic         sib_i = 1'b1;
  logic         req_valid_o;
  logic [63:0]  req_addr_o;
  logic         req_ready_i = 1'b0;
  logic         rsp_valid_i = 1'b0;
  logic [31:0]  rsp_data_i = '0;
  logic         rsp_fault_i = 1'b0;
  logic [255:0] dest_o, mask_o;
  logic         done_o, fault_o, illegal_o;
  logic [2:0]   fault_elem_o;

  int errors = 0;
  int checks = 0;

  // memory model configuration
  logic [63:0] fault_addr = '0;
  bit          fault_en = 1'b0;
  int          lat_cfg = 0;
  bit          slow_ready = 1'b0;

  // scoreboard
  logic [255:0] exp_d_q[$];
  logic [255:0] exp_m_q[$];
  bit           exp_f_q[$];
  int           exp_e_q[$];
  bit           exp_i_q[$];
  string        tag_q[$];
  logic [63:0]  addr_q[$];

  always #4 clk = ~clk;

  vgather_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .index_i(index_i),
    .idx64_i(idx64_i), .scale_i(scale_i), .disp_i(disp_i), .amode_i(amode_i),
    .wide_i(wide_i), .mask_i(mask_i), .dest_i(dest_i), .idx_reg_i(idx_reg_i),
    .mask_reg_i(mask_reg_i), .dest_reg_i(dest_reg_i), .sib_i(sib_i),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o), .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rsp_fault_i(rsp_fault_i),
    .dest_o(dest_o), .mask_o(mask_o), .done_o(done_o), .fault_o(fault_o),
    .fault_elem_o(fault_elem_o), .illegal_o(illegal_o)
  );

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return (a[31:0] * 32'h9E37_79B1) ^ a[63:32] ^ 32'h1234_5678;
  endfunction

  function automatic logic [255:0] pack8(input logic [31:0] a0, a1, a2, a3, a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  function automatic logic [255:0] pack4q(input logic [63:0] q0, q1, q2, q3);
    return {q3, q2, q1, q0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory: accepts one request, answers after lat_cfg further cycles.
  initial begin
    bit          pending = 1'b0;
    logic [63:0] pend_addr = '0;
    int          wait_left = 0;
    int          cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid_i = 1'b0;
      rsp_fault_i = 1'b0;
      if (!rst_n) begin
        pending = 1'b0;
        req_ready_i = 1'b0;
      end else if (pending) begin
        req_ready_i = 1'b0;
        if (wait_left == 0) begin
          rsp_valid_i = 1'b1;
          rsp_data_i  = mem_word(pend_addr);
          rsp_fault_i = fault_en && (pend_addr == fault_addr);
          pending = 1'b0;
        end else begin
          wait_left--;
        end
      end else begin
        req_ready_i = slow_ready ? ((cyc % 3) == 2) : 1'b1;
        if (req_valid_o && req_ready_i) begin
          pending   = 1'b1;
          pend_addr = req_addr_o;
          wait_left = lat_cfg;
          if (addr_q.size() == 0) begin
            chk(1'b0, "R9/R10", "unexpected request", 256'(req_addr_o), '0);
          end else begin
            logic [63:0] ea;
            ea = addr_q.pop_front();
            chk(req_addr_o == ea, "R2/R10", "request address", 256'(req_addr_o), 256'(ea));
          end
        end
      end
    end
  end

  // Monitor: compares the result each time done rises.
  initial begin
    bit prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done_o && !prev_done) begin
        if (exp_d_q.size() == 0) begin
          chk(1'b0, "R11", "done without a start", 256'(done_o), '0);
        end else begin
          logic [255:0] ed, em;
          bit ef, ei;
          int ee;
          string tg;
          ed = exp_d_q.pop_front(); em = exp_m_q.pop_front();
          ef = exp_f_q.pop_front(); ee = exp_e_q.pop_front();
          ei = exp_i_q.pop_front(); tg = tag_q.pop_front();
          chk(dest_o == ed, tg, "dest", dest_o, ed);
          chk(mask_o == em, tg, "mask", mask_o, em);
          chk(fault_o == ef, tg, "fault flag", 256'(fault_o), 256'(ef));
          if (ef) chk(int'(fault_elem_o) == ee, tg, "fault element",
                      256'(fault_elem_o), 256'(ee));
          chk(illegal_o == ei, tg, "illegal flag", 256'(illegal_o), 256'(ei));
          chk(addr_q.size() == 0, "R10", "requests left unissued",
              256'(addr_q.size()), '0);
          addr_q.delete();
        end
      end
      prev_done = done_o;
    end
  end

  // Driver: computes the expected result, then launches the operation.
  task automatic run_op(input string tag, input logic [63:0] base, input logic [255:0] idx,
                        input bit i64, input logic [1:0] sc, input logic [31:0] disp,
                        input logic [1:0] am, input bit w256, input logic [255:0] msk,
                        input logic [255:0] dst, input logic [3:0] ri, input logic [3:0] rm,
                        input logic [3:0] rd, input bit sib, input bit fen,
                        input logic [63:0] faddr, input int lat, input bit poke);
    logic [255:0] ed, em;
    bit ef, bad, stop;
    int ee, n;
    ed = '0; em = '0; ef = 0; ee = 0; stop = 0;
    bad = (ri == rm) || (ri == rd) || (rm == rd) || (am == 2'b00) || !sib;
    if (bad) begin
      ed = dst; em = msk;
    end else begin
      n = w256 ? 8 : 4;
      if (i64) n = n / 2;
      for (int j = 0; j < n; j++) begin
        em[j*32 +: 32] = msk[j*32 + 31] ? 32'hFFFF_FFFF : 32'h0;
        ed[j*32 +: 32] = dst[j*32 +: 32];
      end
      for (int j = 0; j < n; j++) begin
        if (!stop && em[j*32 + 31]) begin
          logic [63:0] si, a;
          si = i64 ? idx[j*64 +: 64] : {{32{idx[j*32 + 31]}}, idx[j*32 +: 32]};
          a  = base + si * (64'd1 << sc) + {{32{disp[31]}}, disp};
          if (am == 2'b01) a = a & 64'h0000_0000_FFFF_FFFF;
          addr_q.push_back(a);
          if (fen && a == faddr) begin
            ef = 1; ee = j; stop = 1;
          end else begin
            ed[j*32 +: 32] = mem_word(a);
            em[j*32 +: 32] = 32'h0;
          end
        end
      end
    end
    exp_d_q.push_back(ed); exp_m_q.push_back(em); exp_f_q.push_back(ef);
    exp_e_q.push_back(ee); exp_i_q.push_back(bad); tag_q.push_back(tag);
    fault_en = fen; fault_addr = faddr; lat_cfg = lat;
    @(negedge clk);
    base_i = base; index_i = idx; idx64_i = i64; scale_i = sc; disp_i = disp;
    amode_i = am; wide_i = w256; mask_i = msk; dest_i = dst;
    idx_reg_i = ri; mask_reg_i = rm; dest_reg_i = rd; sib_i = sib;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R11: a second start while busy, with different operands
      @(negedge clk);
      @(negedge clk);
      mask_i = '1; dest_i = ~dst; base_i = base + 64'h100;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_d_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_o == 1'b1, "R11", "done held", 256'(done_o), 256'(1));
    chk(dest_o == ed && mask_o == em, "R11", "outputs held", dest_o, ed);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] idx_a, msk_a, dst_a, rd_d, rd_m;
    logic [63:0]  base_a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!done_o && !fault_o && !illegal_o && !req_valid_o, "R11", "reset state",
        256'({done_o, fault_o, illegal_o, req_valid_o}), '0);

    base_a = 64'h0000_1000_0000_0000;
    idx_a  = pack8(32'd0, 32'd1, 32'hFFFF_FFFF, 32'd5, 32'd100, 32'hFFFF_FFF9, 32'd3, 32'd2);
    msk_a  = pack8(32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h9000_0001,
                   32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hC000_0000);
    dst_a  = pack8(32'hD000_0000, 32'hD000_0001, 32'hD000_0002, 32'hD000_0003,
                   32'hD000_0004, 32'hD000_0005, 32'hD000_0006, 32'hD000_0007);

    // R2 R3 R4 R5: 32-bit indices, 256-bit length, mixed mask, negative indices
    run_op("R2/R3/R4/R5", base_a, idx_a, 0, 2'd2, 32'h10, 2'b10, 1, msk_a, dst_a,
           4'd1, 4'd2, 4'd3, 1, 0, '0, 0, 0);

    // R7 R1: fault on element 3 (address base + 5*4 + 0x10)
    run_op("R7/R1", base_a, idx_a, 0, 2'd2, 32'h10, 2'b10, 1, msk_a, dst_a,
           4'd1, 4'd2, 4'd3, 1, 1, base_a + 64'h24, 1, 0);
    rd_d = dest_o; rd_m = mask_o;
    // R7: resume from the partial result
    run_op("R7 resume", base_a, idx_a, 0, 2'd2, 32'h10, 2'b10, 1, rd_m, rd_d,
           4'd1, 4'd2, 4'd3, 1, 0, '0, 0, 0);

    // R3 R6: 32-bit indices, 128-bit length; upper lanes zeroed; slow memory
    slow_ready = 1;
    run_op("R3/R6", base_a, idx_a, 0, 2'd0, 32'hFFFF_FFFF, 2'b11, 0, '1, dst_a,
           4'd4, 4'd5, 4'd6, 1, 0, '0, 2, 0);

    // R11: start while busy is ignored
    run_op("R11", base_a, idx_a, 0, 2'd1, 32'h0, 2'b10, 1, msk_a, dst_a,
           4'd1, 4'd2, 4'd3, 1, 0, '0, 3, 1);
    slow_ready = 0;

    // R2 R3 R6: 64-bit indices, 256-bit length, scale 8
    run_op("R2/R3/R6 q256", 64'h0000_0000_0040_0000,
           pack4q(64'h10, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0001_0000_0000, 64'd7),
           1, 2'd3, 32'h8, 2'b10, 1, '1, dst_a, 4'd1, 4'd2, 4'd3, 1, 0, '0, 0, 0);

    // R3 R6 R10: 64-bit indices, 128-bit length, backpressure
    slow_ready = 1;
    run_op("R3/R6/R10 q128", 64'h0000_0000_0040_0000,
           pack4q(64'd5, 64'hFFFF_FFFF_FFFF_FFFD, 64'd9, 64'd9),
           1, 2'd1, 32'h0, 2'b10, 0, '1, dst_a, 4'd1, 4'd2, 4'd3, 1, 0, '0, 1, 0);
    slow_ready = 0;

    // R6 R7: fault on the very first element, 128-bit length
    run_op("R6/R7 first", 64'h0000_0000_0000_8000, idx_a, 0, 2'd0, 32'h0, 2'b10, 0,
           '1, dst_a, 4'd1, 4'd2, 4'd3, 1, 1, 64'h0000_0000_0000_8000, 0, 0);

    // R8 R2: 32-bit addressing drops high bits; odd addresses do not fault
    run_op("R8", 64'h0000_0000_FFFF_FFF0,
           pack8(32'h4000_0000, 32'd3, 32'h0000_0021, 32'hFFFF_FFFF, 0, 0, 0, 0),
           0, 2'd3, 32'h0000_0003, 2'b01, 0, '1, dst_a, 4'd1, 4'd2, 4'd3, 1, 0, '0, 0, 0);
    run_op("R8 odd", 64'h0000_0000_FFFF_FFF0,
           pack8(32'd3, 32'd7, 32'h8000_0001, 32'd1, 0, 0, 0, 0),
           0, 2'd0, 32'h0, 2'b01, 0, '1, dst_a, 4'd1, 4'd2, 4'd3, 1, 0, '0, 0, 0);

    // R4 R5: nothing active, no requests, destination kept
    run_op("R4/R5 empty", base_a, idx_a, 0, 2'd2, 32'h0, 2'b10, 1,
           pack8(32'h7FFF_FFFF, 32'h1, 0, 32'h7000_0000, 0, 0, 32'h2, 0), dst_a,
           4'd1, 4'd2, 4'd3, 1, 0, '0, 0, 0);

    // R9: register clash, 16-bit addressing, missing scaled-index byte
    run_op("R9 clash", base_a, idx_a, 0, 2'd2, 32'h0, 2'b10, 1, msk_a, dst_a,
           4'd1, 4'd2, 4'd2, 1, 0, '0, 0, 0);
    run_op("R9 addr16", base_a, idx_a, 0, 2'd2, 32'h0, 2'b00, 1, msk_a, dst_a,
           4'd1, 4'd2, 4'd3, 1, 0, '0, 0, 0);
    run_op("R9 nosib", base_a, idx_a, 0, 2'd2, 32'h0, 2'b10, 1, msk_a, dst_a,
           4'd1, 4'd2, 4'd3, 0, 0, '0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule